// File: doc/BRIEF.md
# I2C Master Start-Condition Sequencer

This block makes the opening bus condition of an I2C master: it pulls SDA low while SCL is high, then pulls SCL low. It drives the two open-drain lines through pull-low enables and watches the real line levels through a two-stage synchronizer. A reloadable down-counter sets the length of each of its two phases. A one-cycle request pulse starts the sequence. A pending bit stays high while the sequence runs and falls by itself when the sequence ends.

The block copes with a second master on the same bus. If either line is already low when the request is checked, the sequence is abandoned. It is also abandoned if SCL drops while SDA is still high during the first phase. In both cases a sticky collision flag is raised. If SDA is pulled low early by someone else, this is not a collision. The block cuts its first phase short and pulls SDA at once, so both masters can go on to arbitrate the address. A bus monitor raises a Start-seen status bit and a sticky interrupt whenever SDA falls while SCL is high.

Top module: `i2c_start_gen`

## Requirements
- R1: During and right after reset, sda_oe, scl_oe, start_pend, bus_coll, start_irq and start_seen are all 0. An oe value of 1 means the line is pulled low.
- R2: A start_set pulse seen while start_pend is 0 raises start_pend on the next clock edge. A start_set pulse seen while start_pend is 1 has no effect on the timing of sda_oe, scl_oe or start_pend, and does not start a new sequence.
- R3: One cycle after a request is accepted, the synchronized lines are checked. If either is low, bus_coll is set, start_pend clears, and both lines stay released, all on the same edge.
- R4: After a clean check, the counter is loaded with reload and the block waits reload+1 cycles with SDA released. It then asserts sda_oe. Counting from the cycle in which the request is sampled, sda_oe is first seen reload+3 cycles later.
- R5: If the synchronized SDA is low during the first phase, sda_oe is asserted on the next edge and the counter is reloaded. This has no collision and takes priority over a low SCL.
- R6: If the synchronized SCL is low while the synchronized SDA is high during the first phase, bus_coll is set and start_pend clears. The lines stay released. This wins over the end of the count.
- R7: After sda_oe rises, the counter runs reload+1 more cycles and then scl_oe is asserted. A low SCL during this phase is not a collision.
- R8: start_pend falls on the same edge on which scl_oe rises, or on which bus_coll is set by R3 or R6.
- R9: start_seen and start_irq are set when the synchronized SDA goes from high to low while the synchronized SCL is high. start_seen clears when SDA goes from low to high while SCL is high.
- R10: start_irq and bus_coll stay set until a pulse on irq_clr or coll_clr. A pulse on irq_clr leaves start_seen unchanged.
- R11: The line inputs pass through two flops before any decision. An external SDA fall at cycle e of the first phase (e <= reload) moves the sda_oe rise to cycle e+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_set | input | 1 | One-cycle request to begin a Start |
| reload | input | RELOAD_W | Phase length minus one, in cycles |
| sda_in | input | 1 | Sensed SDA line level |
| scl_in | input | 1 | Sensed SCL line level |
| irq_clr | input | 1 | Clears start_irq |
| coll_clr | input | 1 | Clears bus_coll |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| start_pend | output | 1 | Request in progress; clears by itself |
| start_irq | output | 1 | Sticky flag for a Start seen on the bus |
| bus_coll | output | 1 | Sticky collision flag |
| start_seen | output | 1 | Status: a Start is on the bus |

## Verification
A wrong sequencer state shows up at the pull-low enables and at start_pend within one phase, at most reload+1 cycles. A stuck counter or a wrong priority moves the rise of sda_oe or scl_oe off its computed cycle. A missing abort leaves sda_oe rising where the bench expects bus_coll. Synchronizer depth errors move every early-SDA and SCL-collision time by a whole cycle. Monitor faults appear in start_irq and start_seen within four cycles of a line edge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HOLD_HI,
        ST_HOLD_LO
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       pend;
        logic       sda_drv;
        logic       scl_drv;
        logic       coll;
    } seq_regs_t;

    typedef struct packed {
        logic prev_sda;
        logic prev_scl;
        logic seen;
        logic irq;
    } mon_regs_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] din,
    output logic [N_LINES-1:0] dout
);
    logic [N_LINES-1:0] stage_q [STAGES];
    logic [N_LINES-1:0] stage_d [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = din;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/i2cs_count.sv
module i2cs_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] reload_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)      cnt_d = reload_val;
        else if (dec)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0)); // R4
endmodule

// File: rtl/i2cs_bus_mon.sv
module i2cs_bus_mon
    import i2cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    input  logic irq_clr,
    output logic start_seen,
    output logic start_irq
);
    mon_regs_t m_d, m_q;
    logic fall_hit, rise_hit;

    always_comb begin
        m_d          = m_q;
        fall_hit     = m_q.prev_sda && !sda_s && scl_s;
        rise_hit     = !m_q.prev_sda && sda_s && scl_s;
        m_d.prev_sda = sda_s;
        m_d.prev_scl = scl_s;
        if (fall_hit)      m_d.seen = 1'b1;
        else if (rise_hit) m_d.seen = 1'b0;
        if (fall_hit)      m_d.irq  = 1'b1;
        else if (irq_clr)  m_d.irq  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '{prev_sda: 1'b1, prev_scl: 1'b1, seen: 1'b0, irq: 1'b0};
        else        m_q <= m_d;
    end

    assign start_seen = m_q.seen;
    assign start_irq  = m_q.irq;

    AST_IRQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_irq) |-> ($past(!sda_s) && $past(scl_s))); // R9
    AST_SEEN_DROPS_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_seen) |-> ($past(sda_s) && $past(scl_s))); // R9
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2cs_pkg::*;
#(
    parameter int RELOAD_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_set,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                sda_in,
    input  logic                scl_in,
    input  logic                irq_clr,
    input  logic                coll_clr,
    output logic                sda_oe,
    output logic                scl_oe,
    output logic                start_pend,
    output logic                start_irq,
    output logic                bus_coll,
    output logic                start_seen
);
    localparam int N_LINES = 2;
    localparam int IDX_SDA = 0;
    localparam int IDX_SCL = 1;

    logic [N_LINES-1:0] lines_raw, lines_s;
    logic sda_s, scl_s;
    logic cnt_load, cnt_dec, cnt_zero;
    logic coll_set;
    seq_regs_t r_d, r_q;

    assign lines_raw[IDX_SDA] = sda_in;
    assign lines_raw[IDX_SCL] = scl_in;

    i2cs_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(lines_raw), .dout(lines_s)
    );

    assign sda_s = lines_s[IDX_SDA];
    assign scl_s = lines_s[IDX_SCL];

    i2cs_count #(.W(RELOAD_W)) u_count (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .dec(cnt_dec),
        .reload_val(reload), .zero(cnt_zero)
    );

    i2cs_bus_mon u_mon (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_s(scl_s),
        .irq_clr(irq_clr), .start_seen(start_seen), .start_irq(start_irq)
    );

    always_comb begin
        r_d      = r_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        coll_set = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_set) begin
                    r_d.state   = ST_CHECK;
                    r_d.pend    = 1'b1;
                    r_d.sda_drv = 1'b0;
                    r_d.scl_drv = 1'b0;
                end
            end
            ST_CHECK: begin
                if (!sda_s || !scl_s) begin
                    coll_set = 1'b1;
                end else begin
                    cnt_load  = 1'b1;
                    r_d.state = ST_HOLD_HI;
                end
            end
            ST_HOLD_HI: begin
                if (!sda_s || cnt_zero) begin
                    if (sda_s && !scl_s) begin
                        coll_set = 1'b1;
                    end else begin
                        r_d.sda_drv = 1'b1;
                        cnt_load    = 1'b1;
                        r_d.state   = ST_HOLD_LO;
                    end
                end else if (!scl_s) begin
                    coll_set = 1'b1;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_HOLD_LO: begin
                if (cnt_zero) begin
                    r_d.scl_drv = 1'b1;
                    r_d.pend    = 1'b0;
                    r_d.state   = ST_IDLE;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (coll_set) begin
            r_d.state   = ST_IDLE;
            r_d.pend    = 1'b0;
            r_d.sda_drv = 1'b0;
            r_d.scl_drv = 1'b0;
        end
        r_d.coll = coll_set | (r_q.coll & ~coll_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, pend: 1'b0, sda_drv: 1'b0, scl_drv: 1'b0, coll: 1'b0};
        else        r_q <= r_d;
    end

    assign sda_oe     = r_q.sda_drv;
    assign scl_oe     = r_q.scl_drv;
    assign start_pend = r_q.pend;
    assign bus_coll   = r_q.coll;

    AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_set && !start_pend) |=> start_pend); // R2
    AST_SDA_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (start_pend && $past(start_pend))); // R4
    AST_SCL_AFTER_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> sda_oe); // R7
    AST_SCL_ENDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> (!start_pend && $past(start_pend))); // R8
    AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_coll) |-> (!start_pend && !sda_oe && !scl_oe)); // R6
endmodule

// File: tb/i2c_start_gen_test.sv
`timescale 1ns/1ps
module i2c_start_gen_test;
    localparam int RW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_set = 1'b0;
    logic [RW-1:0] reload = '0;
    logic irq_clr = 1'b0, coll_clr = 1'b0;
    logic ext_sda_low = 1'b0, ext_scl_low = 1'b0;
    logic sda_oe, scl_oe, start_pend, start_irq, bus_coll, start_seen;
    logic sda_line, scl_line;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign sda_line = !(sda_oe || ext_sda_low);
    assign scl_line = !(scl_oe || ext_scl_low);

    i2c_start_gen #(.RELOAD_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .reload(reload),
        .sda_in(sda_line), .scl_in(scl_line), .irq_clr(irq_clr), .coll_clr(coll_clr),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .start_pend(start_pend),
        .start_irq(start_irq), .bus_coll(bus_coll), .start_seen(start_seen)
    );

    // mode: 0 none, 1 SDA pulled early at ev, 2 SCL low in first phase at ev,
    // 3 SCL low in second phase at ev, 4 SDA low beforehand, 5 SCL low beforehand
    typedef struct packed {
        int rl; int md; int ev; int e_sda; int e_scl; int e_coll; int e_irq;
    } row_t;

    localparam int NROWS = 12;
    localparam row_t ROWS [NROWS] = '{
        '{3, 0, 0, 6, 10, 0, 1},
        '{0, 0, 0, 3, 4, 0, 1},
        '{5, 1, 2, 5, 11, 0, 1},
        '{5, 1, 0, 3, 9, 0, 1},
        '{4, 1, 4, 7, 12, 0, 1},
        '{6, 2, 3, 0, 0, 6, 0},
        '{2, 2, 0, 0, 0, 3, 0},
        '{4, 3, 8, 7, 12, 0, 1},
        '{3, 4, 0, 0, 0, 2, 1},
        '{3, 5, 0, 0, 0, 2, 0},
        '{20, 0, 0, 23, 44, 0, 1},
        '{5, 2, 5, 0, 0, 8, 0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic sda_busy, input logic scl_busy, input int rl);
        @(negedge clk);
        rst_n = 1'b0;
        start_set = 1'b0; irq_clr = 1'b0; coll_clr = 1'b0;
        ext_sda_low = sda_busy;
        ext_scl_low = scl_busy;
        reload = rl[RW-1:0];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_row(input row_t r, input int idx);
        int g_sda = 0, g_scl = 0, g_coll = 0, g_off = 0;
        string tag_t, tag_c;
        do_reset(r.md == 4, r.md == 5, r.rl);
        start_set = 1'b1;
        if (r.md == 1 && r.ev == 0) ext_sda_low = 1'b1;
        if ((r.md == 2 || r.md == 3) && r.ev == 0) ext_scl_low = 1'b1;
        for (int t = 1; t <= 70; t++) begin
            @(negedge clk);
            if (t == 1) begin
                start_set = 1'b0;
                chk("R2", $sformatf("row %0d pend after accept", idx), start_pend, 1);
            end
            if (sda_oe && g_sda == 0) g_sda = t;
            if (scl_oe && g_scl == 0) g_scl = t;
            if (bus_coll && g_coll == 0) g_coll = t;
            if (!start_pend && g_off == 0) g_off = t;
            if (r.md == 1 && t == r.ev) ext_sda_low = 1'b1;
            if ((r.md == 2 || r.md == 3) && t == r.ev) ext_scl_low = 1'b1;
        end
        tag_t = (r.md == 1) ? "R5/R11" : "R4";
        tag_c = (r.md == 4 || r.md == 5) ? "R3" : "R6";
        chk(tag_t, $sformatf("row %0d sda_oe time", idx), g_sda, r.e_sda);
        chk("R7", $sformatf("row %0d scl_oe time", idx), g_scl, r.e_scl);
        chk(tag_c, $sformatf("row %0d bus_coll time", idx), g_coll, r.e_coll);
        chk("R8", $sformatf("row %0d pend clear time", idx), g_off,
            (r.e_scl != 0) ? r.e_scl : r.e_coll);
        chk("R9", $sformatf("row %0d start_irq", idx), start_irq, r.e_irq);
        chk("R9", $sformatf("row %0d start_seen", idx), start_seen, r.e_irq);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int g_sda, g_scl, g_off, late_pend;
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "sda_oe in reset", sda_oe, 0);
        chk("R1", "scl_oe in reset", scl_oe, 0);
        chk("R1", "flags in reset", {start_pend, bus_coll, start_irq, start_seen}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", {sda_oe, scl_oe, start_pend, bus_coll, start_irq, start_seen}, 0);

        for (int i = 0; i < NROWS; i++) run_row(ROWS[i], i);

        // R2: extra requests during the sequence are ignored
        do_reset(1'b0, 1'b0, 3);
        g_sda = 0; g_scl = 0; g_off = 0; late_pend = 0;
        start_set = 1'b1;
        for (int t = 1; t <= 20; t++) begin
            @(negedge clk);
            start_set = (t == 3 || t == 8);
            if (sda_oe && g_sda == 0) g_sda = t;
            if (scl_oe && g_scl == 0) g_scl = t;
            if (!start_pend && g_off == 0) g_off = t;
            if (t > 10 && start_pend) late_pend = 1;
        end
        chk("R2", "sda_oe time with extra requests", g_sda, 6);
        chk("R2", "scl_oe time with extra requests", g_scl, 10);
        chk("R2", "pend clear time with extra requests", g_off, 10);
        chk("R2", "no restart after completion", late_pend, 0);

        // R10: sticky irq cleared by irq_clr, start_seen untouched
        repeat (5) @(negedge clk);
        chk("R10", "irq holds", start_irq, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        @(negedge clk);
        chk("R10", "irq cleared", start_irq, 0);
        chk("R10", "start_seen kept", start_seen, 1);

        // R10: sticky collision cleared by coll_clr
        do_reset(1'b0, 1'b1, 2);
        start_set = 1'b1;
        @(negedge clk);
        start_set = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10", "coll holds", bus_coll, 1);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        @(negedge clk);
        chk("R10", "coll cleared", bus_coll, 0);

        // R9: monitor with external Start and Stop
        do_reset(1'b0, 1'b0, 2);
        ext_sda_low = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9", "seen on external start", start_seen, 1);
        chk("R9", "irq on external start", start_irq, 1);
        ext_sda_low = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9", "seen cleared on stop", start_seen, 0);
        chk("R10", "irq kept after stop", start_irq, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule